// File: doc/BRIEF.md
# GPIO Output-Enable Set/Clear Register Bank

This block holds the control and status state for four general-purpose I/O pins. It sits behind a 32-bit register bus that is addressed by dword and carries active-low per-byte write enables, as a configuration-space slave would. One dword holds the whole bank. Byte 1 holds the output data value. Byte 2 carries two 4-bit fields that act on a single shared output-enable vector: the upper field sets enable bits and the lower field clears them. Byte 3 returns the sampled pin levels and a reserved nibble.

The bank drives a per-pin output enable and a per-pin output value toward the pads. A pin whose enable is 0 is input-only, and its driver is tristated. A pin whose enable is 1 drives its bit of the output data register. Reads decode the address only, ignore the byte enables and change no state.

Top module: `gpio_setclr_bank`

## Requirements
- R1: While reset is asserted and after it is released, `pin_oe` and `pin_out` are 0, and read bits 23:8 of the bank dword are 0.
- R2: A write that enables byte lane 2 sets every output-enable bit for which write data bits 23:20 hold a 1.
- R3: A write that enables byte lane 2 clears every output-enable bit for which write data bits 19:16 hold a 1, so that pin becomes input-only (`pin_oe` bit = 0).
- R4: A 0 in either nibble of byte 2 leaves the matching output-enable bit unchanged.
- R5: If one write carries a 1 for the same pin in both the set nibble and the clear nibble, the clear wins and the pin becomes input-only.
- R6: `be_n` is active-low, one bit per byte lane. Byte 2 is written only when `be_n[2]` = 0, and byte 1 is written only when `be_n[1]` = 0.
- R7: Write data bits 11:8, written through byte lane 1, are stored as the output data and driven on `pin_out`. Read bits 15:12 return 0.
- R8: A read of the bank dword returns the output-enable state in both bits 19:16 and bits 23:20, the output data in bits 11:8, and 0 in bits 27:24 and 7:0, whatever the byte enables are.
- R9: Read bits 31:28 return `pin_in` as captured by one register stage, so a change on the pins is visible after the next clock edge and not before it.
- R10: Writes to byte lanes 0 and 3 change nothing. Writes to any other dword address change nothing. A read of any other dword address returns 0.
- R11: The output-enable and output-data state changes only on a write to the bank dword, and reads never alter it.
- R12: A write accepted at a clock edge is visible on `pin_oe`, `pin_out` and the read data directly after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for the current bus cycle |
| addr | input | 6 | Dword address (byte address divided by four) |
| be_n | input | 4 | Active-low byte-lane write enables |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed dword, 0 when the address misses |
| pin_in | input | 4 | Pin levels from the pads |
| pin_oe | output | 4 | Per-pin output driver enable, 1 = driving |
| pin_out | output | 4 | Per-pin output value |

## Verification
A write accepted at a rising edge must show on `pin_oe`, `pin_out` and the read word after that same edge. A pin change must reach read bits 31:28 exactly one edge later. Read data is combinational from the address and the held state, so it must already be valid within the cycle in which the address is presented. The bench drives every input on the falling edge and checks the read word a short delay later, which shows the state left by the previous rising edge and the pin value captured before the new one. It then lets a rising edge pass and checks the registered outputs against a reference model, which it updates at that edge from the same inputs.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned LANES      = DATA_W / 8;
  localparam int unsigned NIB_W      = 4;
  localparam int unsigned LANE_DOUT  = 1;
  localparam int unsigned LANE_OE    = 2;
  localparam int unsigned DOUT_LSB   = 8;
  localparam int unsigned OE_CLR_LSB = 16;
  localparam int unsigned OE_SET_LSB = 20;
  localparam int unsigned DIN_LSB    = 28;

  typedef struct packed {
    logic dout_stb;
    logic oe_stb;
  } lane_stb_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_bank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned REG_ADDR = 6'h19
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be_n,
  output logic              hit,
  output lane_stb_t         stb
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(REG_ADDR);

  always_comb begin
    hit          = (addr == MATCH);
    stb.dout_stb = wr_en && hit && !be_n[LANE_DOUT];
    stb.oe_stb   = wr_en && hit && !be_n[LANE_OE];
  end
endmodule

// File: rtl/gpio_oe_ctrl.sv
module gpio_oe_ctrl #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                oe_stb,
  input  logic [NUM_PINS-1:0] set_bits,
  input  logic [NUM_PINS-1:0] clr_bits,
  output logic [NUM_PINS-1:0] oe_q
);
  logic [NUM_PINS-1:0] oe_nxt;

  always_comb begin
    oe_nxt = oe_q;
    if (oe_stb) oe_nxt = (oe_q | set_bits) & ~clr_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      oe_q <= '0;
    else if (oe_stb) oe_q <= oe_nxt;
  end

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    oe_stb |=> ((oe_q & $past(set_bits & ~clr_bits)) == $past(set_bits & ~clr_bits)));
  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_stb |=> ((oe_q & $past(clr_bits)) == '0));
  assert_zero_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oe_stb |=> ((oe_q & ~$past(set_bits | clr_bits)) == ($past(oe_q) & ~$past(set_bits | clr_bits))));
  assert_oe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_stb |=> $stable(oe_q));
endmodule

// File: rtl/gpio_dout_reg.sv
module gpio_dout_reg #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dout_stb,
  input  logic [NUM_PINS-1:0] dout_wr,
  output logic [NUM_PINS-1:0] dout_q
);
  logic [NUM_PINS-1:0] dout_nxt;

  always_comb begin
    dout_nxt = dout_q;
    if (dout_stb) dout_nxt = dout_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dout_q <= '0;
    else if (dout_stb) dout_q <= dout_nxt;
  end

  assert_dout_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dout_stb |=> (dout_q == $past(dout_wr)));
  assert_dout_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_stb |=> $stable(dout_q));
endmodule

// File: rtl/gpio_in_sample.sv
module gpio_in_sample #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_in;
  end

  assert_one_stage_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin_q == $past(pin_in)));
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned REG_ADDR = 6'h19
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [LANES-1:0]    be_n,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out
);
  localparam int unsigned PINS_OK = (NUM_PINS >= 1 && NUM_PINS <= NIB_W) ? 1 : 0;

  generate
    if (PINS_OK == 0) begin : g_bad_pins
      initial $error("NUM_PINS must lie between 1 and %0d", NIB_W);
    end
  endgenerate

  logic                rst_sync_n;
  logic                hit;
  lane_stb_t           stb;
  logic [NUM_PINS-1:0] oe_q;
  logic [NUM_PINS-1:0] dout_q;
  logic [NUM_PINS-1:0] pin_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gpio_bus_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .wr_en (wr_en),
    .addr  (addr),
    .be_n  (be_n),
    .hit   (hit),
    .stb   (stb)
  );

  gpio_oe_ctrl #(.NUM_PINS(NUM_PINS)) u_oe (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .oe_stb   (stb.oe_stb),
    .set_bits (wdata[OE_SET_LSB +: NUM_PINS]),
    .clr_bits (wdata[OE_CLR_LSB +: NUM_PINS]),
    .oe_q     (oe_q)
  );

  gpio_dout_reg #(.NUM_PINS(NUM_PINS)) u_dout (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .dout_stb (stb.dout_stb),
    .dout_wr  (wdata[DOUT_LSB +: NUM_PINS]),
    .dout_q   (dout_q)
  );

  gpio_in_sample #(.NUM_PINS(NUM_PINS)) u_in (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_in (pin_in),
    .pin_q  (pin_q)
  );

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata[DOUT_LSB   +: NUM_PINS] = dout_q;
      rdata[OE_CLR_LSB +: NUM_PINS] = oe_q;
      rdata[OE_SET_LSB +: NUM_PINS] = oe_q;
      rdata[DIN_LSB    +: NUM_PINS] = pin_q;
    end
  end

  assign pin_oe  = oe_q;
  assign pin_out = dout_q;

  assert_miss_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |-> (rdata == '0));
  assert_no_write_no_change_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> ($stable(pin_oe) && $stable(pin_out)));
  assert_fields_agree_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |-> (rdata[OE_SET_LSB +: NIB_W] == rdata[OE_CLR_LSB +: NIB_W]));
endmodule

// File: tb/tb_gpio_setclr_bank.sv
`timescale 1ns/1ps
module tb_gpio_setclr_bank;
  localparam logic [5:0] BANK = 6'h19;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [5:0]  addr;
  logic [3:0]  be_n;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  pin_in;
  logic [3:0]  pin_oe;
  logic [3:0]  pin_out;

  int unsigned n_tests;
  int unsigned n_fail;
  logic [3:0]  oe_m;
  logic [3:0]  out_m;
  logic [3:0]  in_m;

  gpio_setclr_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .be_n(be_n),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] exp_read(input logic [5:0] a);
    logic [31:0] r;
    r = '0;
    if (a == BANK) begin
      r[11:8]  = out_m;
      r[19:16] = oe_m;
      r[23:20] = oe_m;
      r[31:28] = in_m;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic [5:0] a, input logic [3:0] ben,
                      input logic [31:0] d, input logic [3:0] pins);
    @(negedge clk);
    wr_en = w; addr = a; be_n = ben; wdata = d; pin_in = pins;
    #1;
    check(rdata == exp_read(a), "R8 read word", rdata, exp_read(a));
    check(pin_oe == oe_m, "R12 pin_oe", {28'd0, pin_oe}, {28'd0, oe_m});
    check(pin_out == out_m, "R12 pin_out", {28'd0, pin_out}, {28'd0, out_m});
    @(posedge clk);
    if (w && a == BANK) begin
      if (!ben[1]) out_m = d[11:8];
      if (!ben[2]) oe_m = (oe_m | d[23:20]) & ~d[19:16];
    end
    in_m = pins;
  endtask

  task automatic idle();
    step(1'b0, BANK, 4'hF, 32'h0, pin_in);
    @(negedge clk);
    #1;
  endtask

  initial begin
    int unsigned cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d cycles expected under 100000", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    n_tests = 0; n_fail = 0;
    oe_m = '0; out_m = '0; in_m = '0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 1'b0; addr = BANK; be_n = 4'hF; wdata = '0; pin_in = 4'h0;
    repeat (3) @(negedge clk);
    #1;
    // R1: held in reset
    check(pin_oe == 4'h0 && pin_out == 4'h0, "R1 reset outputs", {24'd0, pin_oe, pin_out}, 32'h0);
    check(rdata[23:8] == 16'h0, "R1 reset read", rdata, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(pin_oe == 4'h0 && pin_out == 4'h0, "R1 after release", {24'd0, pin_oe, pin_out}, 32'h0);

    // R2: set nibble enables pins
    step(1'b1, BANK, 4'b1011, 32'h00F0_0000, 4'h0);
    idle();
    check(pin_oe == 4'hF, "R2 set all", {28'd0, pin_oe}, 32'hF);
    // R3: clear nibble disables pins
    step(1'b1, BANK, 4'b1011, 32'h0005_0000, 4'h0);
    idle();
    check(pin_oe == 4'hA, "R3 clear 0x5", {28'd0, pin_oe}, 32'hA);
    // R4: zero nibbles keep state
    step(1'b1, BANK, 4'b1011, 32'h0000_0000, 4'h0);
    idle();
    check(pin_oe == 4'hA, "R4 zero write", {28'd0, pin_oe}, 32'hA);
    // R5: same bit set and cleared -> cleared
    step(1'b1, BANK, 4'b1011, 32'h0031_0000, 4'h0);
    idle();
    check(pin_oe == 4'hA, "R5 clear wins", {28'd0, pin_oe}, 32'hA);
    step(1'b1, BANK, 4'b1011, 32'h0088_0000, 4'h0);
    idle();
    check(pin_oe == 4'h2, "R5 clear wins bit3", {28'd0, pin_oe}, 32'h2);
    // R6: lane 2 disabled -> no change
    step(1'b1, BANK, 4'b1111, 32'h00F0_0F00, 4'h0);
    idle();
    check(pin_oe == 4'h2 && pin_out == 4'h0, "R6 lanes off", {24'd0, pin_oe, pin_out}, 32'h20);
    // R7: output data via lane 1, bits 15:12 read zero
    step(1'b1, BANK, 4'b1101, 32'h00F0_F600, 4'h0);
    idle();
    check(pin_out == 4'h6 && pin_oe == 4'h2, "R7 dout load", {24'd0, pin_oe, pin_out}, 32'h26);
    check(rdata[15:8] == 8'h06, "R7 dout readback", rdata, 32'h0000_0600);
    // R10: lanes 0 and 3 ignored, other address ignored
    step(1'b1, BANK, 4'b0110, 32'hFFFF_FFFF, 4'h0);
    idle();
    check(pin_oe == 4'h2 && pin_out == 4'h6, "R10 lanes 0/3", {24'd0, pin_oe, pin_out}, 32'h26);
    check(rdata[27:24] == 4'h0 && rdata[7:0] == 8'h0, "R10 reserved zero", rdata, 32'h0022_0600);
    step(1'b1, 6'h18, 4'b0000, 32'h00FF_0F00, 4'h0);
    idle();
    check(pin_oe == 4'h2 && pin_out == 4'h6, "R10 other address", {24'd0, pin_oe, pin_out}, 32'h26);
    @(negedge clk); addr = 6'h1A; #1;
    check(rdata == 32'h0, "R10 miss read", rdata, 32'h0);
    // R9: pin change visible one edge later
    @(negedge clk); addr = BANK; wr_en = 1'b0; pin_in = 4'h9; #1;
    check(rdata[31:28] == 4'h0, "R9 before edge", rdata, 32'h0);
    @(negedge clk); #1;
    check(rdata[31:28] == 4'h9, "R9 after edge", rdata, 32'h9000_0000);
    in_m = 4'h9;
    // R11: reads with any byte enables leave state alone
    step(1'b0, BANK, 4'b0000, 32'hFFFF_FFFF, 4'h9);
    idle();
    check(pin_oe == 4'h2 && pin_out == 4'h6, "R11 read no effect", {24'd0, pin_oe, pin_out}, 32'h26);

    // Random mix, checked each cycle by step (R8, R12)
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] a;
      a = ($urandom % 4 != 0) ? BANK : 6'($urandom);
      step(1'($urandom), a, 4'($urandom), $urandom, 4'($urandom));
    end
    idle();
    check(pin_oe == oe_m && pin_out == out_m, "R12 final state",
          {24'd0, pin_oe, pin_out}, {24'd0, oe_m, out_m});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule